// File: doc/BRIEF.md
# Move Instruction Decoder with One-Shot Prefix

This block decodes 16-bit instruction words in which every instruction is a transfer from a source to a destination. Each word has three parts: a format bit, a destination descriptor made of a module number and a subdecode, and a source. The source is either a register descriptor (module and subdecode) or an 8-bit literal. The decoder widens every subdecode to 5 bits and every literal to 16 bits, then presents the result one clock after the word is accepted.

A word that writes to the prefix module does not change what the decoder does with that word itself. It loads a short-lived prefix register, which holds two things. The first is a high byte for the next literal. The second is three extra address bits that reach subdecodes above 7 on the destination side and above 15 on the source side. The prefix lives for exactly one cycle and is then cleared. While it is held, the decoder raises an interrupt-inhibit signal so that nothing can separate the pair. Executing the decoded moves is left to downstream logic.

Top module: `mvdec_top`

## Requirements
- R1: While reset is applied, and until the first word is accepted after reset, `out_vld_o`, `pfx_active_o` and `irq_inhibit_o` are 0 and every decoded field is 0.
- R2: A word with `insn_vld_i` high at a rising edge appears decoded after that edge with `out_vld_o` high. The decode follows these rules:
  - Bit 15 gives `fmt_reg_o`.
  - Bits 11:8 give the destination module and bits 14:12 the low three destination subdecode bits.
  - In register form (bit 15 = 1), bits 3:0 give the source module and bits 7:4 the low four source subdecode bits.
  - Example: 0xBF09 gives destination module 15 subdecode 3 and source module 9 subdecode 0. Example: 0xDA3A gives destination 10/5 and source 10/3.
- R3: In immediate form (bit 15 = 0), `imm_o` carries bits 7:0 in its low byte, and the source module and subdecode outputs are 0. With no prefix the high byte is 0, so 0x0923 gives literal 0x0023 into module 9 subdecode 0. In register form `imm_o` is 0.
- R4: A word decoded with no live prefix has destination subdecode bits 4:3 equal to 0 and source subdecode bit 4 equal to 0.
- R5: A valid word whose destination module is 11 loads the prefix. The prefix high byte is that word's bits 7:0 in immediate form and 0 in register form. The next word then takes that byte as the high byte of its literal.
- R6: The three destination-subdecode bits of the prefix word (its bits 14:12, numbered 2:0) map as follows:
  - Prefix bit 1 sets destination subdecode bit 3.
  - Prefix bit 0 sets destination subdecode bit 4.
  - Prefix bit 2 sets source subdecode bit 4.
  - Example: the pair 0x2B03, 0x2920 decodes to literal 0x0320 into module 9 subdecode 10.
- R7: A prefix is held for one cycle only. If no valid word is accepted in the cycle after it, the prefix is discarded, and the next word decodes without it.
- R8: `irq_inhibit_o` is high exactly during the cycle after a prefix load and low in all other cycles.
- R9: `pfx_active_o` is high together with a decoded word that consumed a prefix, and low for all other decoded words.
- R10: A prefix word that directly follows another prefix word replaces it. Only the second prefix applies to the next word.
- R11: In a cycle with `insn_vld_i` low, the next `out_vld_o` is 0 and all decoded fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| insn_i | input | 16 | Instruction word |
| insn_vld_i | input | 1 | Instruction word valid strobe |
| out_vld_o | output | 1 | Decoded fields below belong to a word accepted at the last edge |
| fmt_reg_o | output | 1 | 1 = register source, 0 = literal source |
| dst_mod_o | output | 4 | Destination module |
| dst_sub_o | output | 5 | Destination subdecode |
| src_mod_o | output | 4 | Source module (0 in immediate form) |
| src_sub_o | output | 5 | Source subdecode (0 in immediate form) |
| imm_o | output | 16 | Literal source value (0 in register form) |
| pfx_active_o | output | 1 | Decoded word consumed a prefix |
| irq_inhibit_o | output | 1 | A prefix is currently held; interrupts must wait |

## Verification
The embedded properties check several rules on every cycle:
- The prefix never outlives one cycle without being reloaded.
- The inhibit signal only follows a prefix load.
- Unprefixed words never show the extended subdecode bits or a non-zero literal high byte.
- A consumed prefix always coincides with inhibit in the previous cycle.
- Idle cycles freeze the outputs.

The bit mapping of the prefix onto the destination and source subdecodes, the choice of high byte for register-form prefixes, and the replacement by a second prefix are shown only by the bench's scenarios. So are the loss of a prefix across an idle cycle and the exact decode of the reference words. The bench compares each of these against its own model of the field layout.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;
  localparam int INSN_W     = 16;
  localparam int MOD_W      = 4;
  localparam int SUB_W      = 5;
  localparam int BYTE_W     = 8;
  localparam int IMM_W      = 2 * BYTE_W;
  localparam int DSUB_RAW_W = 3;
  localparam int SSUB_RAW_W = 4;

  // bit positions inside the instruction word
  localparam int FMT_BIT    = INSN_W - 1;
  localparam int DSUB_LSB   = FMT_BIT - DSUB_RAW_W;
  localparam int DMOD_LSB   = DSUB_LSB - MOD_W;
  localparam int SSUB_LSB   = MOD_W;

  typedef struct packed {
    logic                  fmt_reg;
    logic [DSUB_RAW_W-1:0] dst_sub;
    logic [MOD_W-1:0]      dst_mod;
    logic [SSUB_RAW_W-1:0] src_sub;
    logic [MOD_W-1:0]      src_mod;
    logic [BYTE_W-1:0]     lit;
  } raw_fields_t;

  typedef struct packed {
    logic              live;
    logic [BYTE_W-1:0] hi;
    logic              dst_b3;
    logic              dst_b4;
    logic              src_b4;
  } pfx_t;

  typedef struct packed {
    logic              fmt_reg;
    logic [MOD_W-1:0]  dst_mod;
    logic [SUB_W-1:0]  dst_sub;
    logic [MOD_W-1:0]  src_mod;
    logic [SUB_W-1:0]  src_sub;
    logic [IMM_W-1:0]  imm;
    logic              pfx_used;
  } dec_t;
endpackage

// File: rtl/mvdec_rst_sync.sv
module mvdec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/mvdec_field_split.sv
module mvdec_field_split
  import mvdec_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output raw_fields_t       raw_o
);
  always_comb begin
    raw_o.fmt_reg = insn_i[FMT_BIT];
    raw_o.dst_sub = insn_i[DSUB_LSB +: DSUB_RAW_W];
    raw_o.dst_mod = insn_i[DMOD_LSB +: MOD_W];
    raw_o.src_sub = insn_i[SSUB_LSB +: SSUB_RAW_W];
    raw_o.src_mod = insn_i[0 +: MOD_W];
    raw_o.lit     = insn_i[0 +: BYTE_W];
  end
endmodule

// File: rtl/mvdec_prefix_reg.sv
module mvdec_prefix_reg
  import mvdec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [BYTE_W-1:0]     hi_i,
  input  logic [DSUB_RAW_W-1:0] dsub_i,
  output pfx_t                  pfx_o
);
  pfx_t pfx_q;
  pfx_t pfx_d;

  // one-shot: cleared every cycle unless a new prefix word arrives
  always_comb begin
    pfx_d = '0;
    if (load_i) begin
      pfx_d.live   = 1'b1;
      pfx_d.hi     = hi_i;
      pfx_d.dst_b3 = dsub_i[1];
      pfx_d.dst_b4 = dsub_i[0];
      pfx_d.src_b4 = dsub_i[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfx_q <= '0;
    else        pfx_q <= pfx_d;
  end

  assign pfx_o = pfx_q;

  // R7: a held prefix is gone one cycle later unless reloaded
  p_pfx_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_q.live && !load_i) |=> !pfx_q.live);

  // R8: a held prefix always stems from a load at the previous edge
  p_pfx_from_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_q.live |-> $past(load_i));
endmodule

// File: rtl/mvdec_merge.sv
module mvdec_merge
  import mvdec_pkg::*;
(
  input  raw_fields_t raw_i,
  input  pfx_t        pfx_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.fmt_reg  = raw_i.fmt_reg;
    dec_o.dst_mod  = raw_i.dst_mod;
    dec_o.dst_sub  = {pfx_i.dst_b4, pfx_i.dst_b3, raw_i.dst_sub};
    dec_o.pfx_used = pfx_i.live;
    if (raw_i.fmt_reg) begin
      dec_o.src_mod = raw_i.src_mod;
      dec_o.src_sub = {pfx_i.src_b4, raw_i.src_sub};
    end else begin
      dec_o.imm     = {pfx_i.hi, raw_i.lit};
    end
  end
endmodule

// File: rtl/mvdec_top.sv
module mvdec_top
  import mvdec_pkg::*;
#(
  parameter logic [MOD_W-1:0] PFX_MODULE  = 4'd11,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn_i,
  input  logic              insn_vld_i,
  output logic              out_vld_o,
  output logic              fmt_reg_o,
  output logic [MOD_W-1:0]  dst_mod_o,
  output logic [SUB_W-1:0]  dst_sub_o,
  output logic [MOD_W-1:0]  src_mod_o,
  output logic [SUB_W-1:0]  src_sub_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              pfx_active_o,
  output logic              irq_inhibit_o
);
  logic        rst_q_n;
  raw_fields_t raw;
  pfx_t        pfx;
  dec_t        dec;
  dec_t        out_q, out_d;
  logic        vld_q, vld_d;
  logic        pfx_load;
  logic [BYTE_W-1:0] pfx_hi;

  mvdec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  mvdec_field_split u_split (
    .insn_i (insn_i),
    .raw_o  (raw)
  );

  always_comb begin
    pfx_load = insn_vld_i && (raw.dst_mod == PFX_MODULE);
    pfx_hi   = raw.fmt_reg ? '0 : raw.lit;
  end

  mvdec_prefix_reg u_pfx (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .load_i (pfx_load),
    .hi_i   (pfx_hi),
    .dsub_i (raw.dst_sub),
    .pfx_o  (pfx)
  );

  mvdec_merge u_merge (
    .raw_i (raw),
    .pfx_i (pfx),
    .dec_o (dec)
  );

  // output stage: next state, then register with explicit enable
  always_comb begin
    vld_d = insn_vld_i;
    out_d = insn_vld_i ? dec : out_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else begin
      vld_q <= vld_d;
      out_q <= out_d;
    end
  end

  assign out_vld_o     = vld_q;
  assign fmt_reg_o     = out_q.fmt_reg;
  assign dst_mod_o     = out_q.dst_mod;
  assign dst_sub_o     = out_q.dst_sub;
  assign src_mod_o     = out_q.src_mod;
  assign src_sub_o     = out_q.src_sub;
  assign imm_o         = out_q.imm;
  assign pfx_active_o  = out_q.pfx_used;
  assign irq_inhibit_o = pfx.live;

  // R4: without a prefix the extended subdecode bits stay clear
  p_narrow_sub_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld_o && !pfx_active_o) |-> (dst_sub_o[SUB_W-1:DSUB_RAW_W] == '0 && src_sub_o[SUB_W-1] == 1'b0));

  // R3: unprefixed literal is zero-extended
  p_imm_zext_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld_o && !fmt_reg_o && !pfx_active_o) |-> (imm_o[IMM_W-1:BYTE_W] == '0));

  // R11: idle cycle yields no output and frozen fields
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !insn_vld_i |=> (!out_vld_o && $stable(dst_mod_o) && $stable(dst_sub_o) && $stable(imm_o) && $stable(src_sub_o)));

  // R9: a consumed prefix was held (inhibit high) in the cycle before
  p_used_after_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_vld_o && pfx_active_o) |-> $past(irq_inhibit_o));
endmodule

// File: tb/test_mvdec_top.sv
`timescale 1ns/1ps
module test_mvdec_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] insn_i;
  logic        insn_vld_i;
  logic        out_vld_o, fmt_reg_o, pfx_active_o, irq_inhibit_o;
  logic [3:0]  dst_mod_o, src_mod_o;
  logic [4:0]  dst_sub_o, src_sub_o;
  logic [15:0] imm_o;

  always #2.5 clk = ~clk;

  mvdec_top i_mvdec_top (
    .clk (clk), .rst_n (rst_n), .insn_i (insn_i), .insn_vld_i (insn_vld_i),
    .out_vld_o (out_vld_o), .fmt_reg_o (fmt_reg_o), .dst_mod_o (dst_mod_o),
    .dst_sub_o (dst_sub_o), .src_mod_o (src_mod_o), .src_sub_o (src_sub_o),
    .imm_o (imm_o), .pfx_active_o (pfx_active_o), .irq_inhibit_o (irq_inhibit_o)
  );

  typedef struct packed {
    logic        fmt;
    logic [3:0]  dmod;
    logic [4:0]  dsub;
    logic [3:0]  smod;
    logic [4:0]  ssub;
    logic [15:0] imm;
    logic        pact;
  } exp_t;

  typedef struct {
    exp_t  v;
    string tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;

  // bench model state of the prefix
  logic       m_live = 0, m_db3 = 0, m_db4 = 0, m_sb4 = 0;
  logic [7:0] m_hi = 0;
  logic       last_v = 0;
  exp_t       last_e = '0;

  function automatic exp_t observed();
    return {fmt_reg_o, dst_mod_o, dst_sub_o, src_mod_o, src_sub_o, imm_o, pfx_active_o};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: checks state left by the previous step, drives, pushes expectation
  task automatic send(input logic [15:0] w, input logic v, input string tag);
    exp_t e;
    @(negedge clk);
    chk(irq_inhibit_o === m_live, "R8 inhibit", 64'(irq_inhibit_o), 64'(m_live));
    chk(out_vld_o === last_v, "R11 out_vld", 64'(out_vld_o), 64'(last_v));
    if (!last_v) chk(observed() === last_e, "R11 hold", 64'(observed()), 64'(last_e));
    insn_i     = w;
    insn_vld_i = v;
    if (v) begin
      e.fmt  = w[15];
      e.dmod = w[11:8];
      e.dsub = {m_db4, m_db3, w[14:12]};
      e.pact = m_live;
      if (w[15]) begin
        e.smod = w[3:0];
        e.ssub = {m_sb4, w[7:4]};
        e.imm  = 16'h0;
      end else begin
        e.smod = 4'h0;
        e.ssub = 5'h0;
        e.imm  = {m_hi, w[7:0]};
      end
      q.push_back('{v: e, tag: tag});
      last_e = e;
      if (w[11:8] == 4'd11) begin
        m_live = 1; m_hi = w[15] ? 8'h0 : w[7:0];
        m_db3 = w[13]; m_db4 = w[12]; m_sb4 = w[14];
      end else begin
        m_live = 0; m_hi = 0; m_db3 = 0; m_db4 = 0; m_sb4 = 0;
      end
    end else begin
      m_live = 0; m_hi = 0; m_db3 = 0; m_db4 = 0; m_sb4 = 0;
    end
    last_v = v;
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n && out_vld_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected output", 64'(observed()), 64'h0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(observed() === it.v, it.tag, 64'(observed()), 64'(it.v));
      end
    end
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; insn_i = 16'h0; insn_vld_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({out_vld_o, pfx_active_o, irq_inhibit_o} === 3'b000, "R1 flags", 64'({out_vld_o, pfx_active_o, irq_inhibit_o}), 64'h0);
    chk(observed() === '0, "R1 fields", 64'(observed()), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_vld_o === 1'b0 && observed() === '0, "R1 after release", 64'(observed()), 64'h0);

    send(16'h0923, 1, "R3 literal 0x0923");
    send(16'hBF09, 1, "R2 register 0xBF09");
    send(16'hDA3A, 1, "R2 nop word 0xDA3A");
    send(16'h0000, 0, "R11 idle");
    send(16'h1C47, 1, "R4 unprefixed widths");
    // R5 R6 R9: reference prefix pair
    send(16'h2B03, 1, "R5 prefix word");
    send(16'h2920, 1, "R6 pair gives 9/10 imm 0x0320");
    // R6: all three extension bits, register form
    send(16'h7B12, 1, "R6 prefix all bits");
    send(16'h8345, 1, "R6 register extended");
    // R5: register-form prefix gives zero high byte
    send(16'hAB39, 1, "R5 register prefix");
    send(16'h0980, 1, "R5 zero high byte");
    // R7: prefix lost across an idle cycle
    send(16'h2B03, 1, "R7 prefix");
    send(16'h0000, 0, "R7 gap");
    send(16'h2920, 1, "R7 decoded without prefix");
    // R10: second prefix replaces first
    send(16'h1BFF, 1, "R10 first prefix");
    send(16'h4B05, 1, "R10 second prefix");
    send(16'h0977, 1, "R10 literal 0x0577");
    send(16'h8F21, 1, "R9 no prefix afterwards");
    send(16'h0000, 0, "R11 idle");
    send(16'h0000, 0, "R11 idle");
    send(16'h0000, 0, "R11 idle");
    chk(q.size() == 0, "R2 all outputs seen", 64'(q.size()), 64'h0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule